// File: doc/BRIEF.md
# Cartridge Command Responder

This block sits on the cartridge side of a host link. It decodes an 8-byte command packet and answers with a stream of 32-bit words, as many as the host asks for. It holds a chip identity word built from the configured ROM size and a NAND-type flag. It has two command phases. In the first, the identity and phase-change opcodes are decoded on the upper nibble. In the second, either a plain-ROM opcode set or a NAND-ROM opcode set applies, chosen by the NAND flag.

In the NAND set, a small 8-bit status register is cleared, marked or read back by dedicated opcodes. ROM data comes from a synchronous memory read port with one cycle of latency, one 32-bit word per request. The byte address moves forward by four for every word the host accepts. Response words leave through a valid/ready handshake. A one-cycle done pulse marks the end of every command.

Top module: `cart_cmd_responder`

## Requirements
- R1: After reset, rsp_valid and rsp_done are low, cmd_ready is high, err_flag and key_enable are low, the status register is zero and the secure phase is active.
- R2: Chip ID bits 7:0 are 0xC2. For a ROM of 128 MiB or less, bits 15:8 are (size in MiB minus 1).
- R3: For a ROM larger than 128 MiB (a multiple of 256 MiB), chip ID bits 15:8 are 0x100 minus (size in MiB divided by 256), taken mod 256.
- R4: Chip ID bit 27 equals cfg_nand, and every other ID bit above 15 is zero.
- R5: In the secure phase, opcode byte (command bits 63:56) 0x1x returns the chip ID in every word. 0x4x returns zero words and sets key_enable. 0xAx returns zero words, and the commands that follow are decoded in the main phase.
- R6: In the main phase, opcode 0xB7 takes a big-endian byte address from command bits 55:24 with bits 1:0 ignored. Word i is the read-port data for address base+4*i, requested one cycle before it is captured.
- R7: A 0xB7 read that crosses a 4 KiB boundary continues at the address that directly follows the end of the page.
- R8: NAND opcode 0x94 clears the status register to zero, so bit 7 ends clear, and returns zero words.
- R9: NAND opcode 0xB2 sets status bit 5 and returns zero words. NAND opcode 0xD6 returns the status byte copied into all four bytes of every word.
- R10: An opcode that is not defined for the current phase and cartridge type returns zero words for the full length and sets err_flag, which stays set until reset. In plain-ROM mode the NAND opcodes count as undefined.
- R11: A command is accepted only while cmd_ready is high. Exactly cmd_len_words words are sent, and each is held stable until rsp_ready. rsp_done pulses for one cycle after the last word is accepted, or one cycle after acceptance when the length is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rom_mib | input | 16 | ROM size in MiB |
| cfg_nand | input | 1 | Cartridge is NAND type |
| cmd_valid | input | 1 | Command packet present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_data | input | 64 | Command packet, byte 0 in bits 63:56 |
| cmd_len_words | input | 10 | Number of response words |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Host takes the response word |
| rsp_data | output | 32 | Response word |
| rsp_done | output | 1 | One-cycle end-of-command pulse |
| rom_rd_en | output | 1 | ROM read request |
| rom_rd_addr | output | 32 | ROM byte address, word aligned |
| rom_rd_data | input | 32 | ROM data, one cycle after request |
| key_enable | output | 1 | Encrypted data output enabled |
| err_flag | output | 1 | Sticky unknown-opcode flag |

## Verification
The checker covers the properties that are local in time on every cycle. These are the handshake rules: a word is held until taken, done never overlaps valid, and no command is taken while words are pending. It also checks word alignment and the one-cycle read latency of the ROM port, that err_flag never falls, and that status bit 7 never sets. Only the bench scenarios can show what the words contain. That covers the ID encoding for small, boundary and large ROMs, the phase change, the read addresses across a page edge, the status sequence of the NAND opcodes, and the rejection of NAND opcodes on a plain-ROM cartridge.

// File: rtl/cart_pkg.sv
// Shared types and constants for the cartridge command responder.
// Assumes: opcode byte is byte 0 of the packet.
package cart_pkg;
    localparam int ROM_MIB_W = 16;

    localparam logic [7:0] OP_ROM_READ  = 8'hB7;
    localparam logic [7:0] OP_NAND_INIT = 8'h94;
    localparam logic [7:0] OP_NAND_SAVE = 8'hB2;
    localparam logic [7:0] OP_NAND_STAT = 8'hD6;
    localparam logic [3:0] NIB_GET_ID   = 4'h1;
    localparam logic [3:0] NIB_KEY_ON   = 4'h4;
    localparam logic [3:0] NIB_TO_MAIN  = 4'hA;

    localparam logic [7:0] ID_LOW_BYTE  = 8'hC2;
    localparam logic [7:0] STAT_SAVE_BIT = 8'h20;

    typedef enum logic [1:0] {FILL_ZERO, FILL_ID, FILL_STATUS, FILL_ROM} fill_e;

    typedef struct packed {
        fill_e fill;
        logic  key_on;
        logic  to_main;
        logic  st_clear;
        logic  st_save;
        logic  bad;
    } dec_t;

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOAD, S_SEND} seq_e;
endpackage

// File: rtl/cart_id_gen.sv
// Chip identity word from ROM size and NAND flag.
// Assumes: size >= 1 MiB; sizes above 128 MiB are multiples of 256 MiB.
module cart_id_gen
    import cart_pkg::*;
(
    input  logic [ROM_MIB_W-1:0] rom_mib,
    input  logic                 nand_type,
    output logic [31:0]          chip_id
);
    logic [7:0] size_code;

    // Size code: small ROMs count MiB, large ones count down in 256 MiB steps.
    always_comb begin
        if (rom_mib <= ROM_MIB_W'(128))
            size_code = rom_mib[7:0] - 8'd1;
        else
            size_code = 8'd0 - rom_mib[15:8];
    end

    // Word layout: type flag in bit 27, size code, fixed low byte.
    assign chip_id = {4'b0, nand_type, 11'b0, size_code, ID_LOW_BYTE};
endmodule

// File: rtl/cart_cmd_decode.sv
// Opcode decoder: maps an opcode, the phase and the cartridge type to
// response fill kind and state side effects. Purely combinational.
module cart_cmd_decode
    import cart_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       main_phase,
    input  logic       nand_type,
    output dec_t       dec
);
    // Phase-dependent decode; anything unlisted is flagged bad.
    always_comb begin
        dec      = '0;
        dec.fill = FILL_ZERO;
        if (!main_phase) begin
            case (opcode[7:4])
                NIB_GET_ID:  dec.fill    = FILL_ID;
                NIB_KEY_ON:  dec.key_on  = 1'b1;
                NIB_TO_MAIN: dec.to_main = 1'b1;
                default:     dec.bad     = 1'b1;
            endcase
        end else if (opcode == OP_ROM_READ) begin
            dec.fill = FILL_ROM;
        end else if (nand_type) begin
            case (opcode)
                OP_NAND_INIT: dec.st_clear = 1'b1;
                OP_NAND_SAVE: dec.st_save  = 1'b1;
                OP_NAND_STAT: dec.fill     = FILL_STATUS;
                default:      dec.bad      = 1'b1;
            endcase
        end else begin
            dec.bad = 1'b1;
        end
    end
endmodule

// File: rtl/cart_word_seq.sv
// Response word sequencer: emits LEN words either from a fixed fill word
// or from a one-cycle-latency ROM port, with valid/ready and a done pulse.
// Assumes: start only while cmd_ready is high.
module cart_word_seq
    import cart_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_rom,
    input  logic [31:0]       start_word,
    output logic              cmd_ready,
    output logic              rom_rd_en,
    output logic [ADDR_W-1:0] rom_rd_addr,
    input  logic [31:0]       rom_rd_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    input  logic              rsp_ready,
    output logic              rsp_done
);
    localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    seq_e              st_q;
    logic [LEN_W-1:0]  len_q, cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rom_q, done_q;
    logic [31:0]       word_q;

    // Sequencer state, counters and captured response word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            len_q  <= '0;
            cnt_q  <= '0;
            addr_q <= '0;
            rom_q  <= 1'b0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    len_q  <= start_len;
                    addr_q <= {start_addr[ADDR_W-1:2], 2'b00};
                    rom_q  <= start_rom;
                    word_q <= start_word;
                    cnt_q  <= '0;
                    if (start_len == '0) done_q <= 1'b1;
                    else st_q <= start_rom ? S_FETCH : S_SEND;
                end
                S_FETCH: st_q <= S_LOAD;
                S_LOAD: begin
                    word_q <= rom_rd_data;
                    st_q   <= S_SEND;
                end
                S_SEND: if (rsp_ready) begin
                    cnt_q  <= cnt_q + LEN_ONE;
                    addr_q <= addr_q + WORD_STEP;
                    if (cnt_q + LEN_ONE == len_q) begin
                        st_q   <= S_IDLE;
                        done_q <= 1'b1;
                    end else if (rom_q) begin
                        st_q <= S_FETCH;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Port outputs decoded from state.
    assign cmd_ready   = (st_q == S_IDLE);
    assign rom_rd_en   = (st_q == S_FETCH);
    assign rom_rd_addr = addr_q;
    assign rsp_valid   = (st_q == S_SEND);
    assign rsp_data    = word_q;
    assign rsp_done    = done_q;
endmodule

// File: rtl/cart_cmd_responder.sv
// Top: cartridge command responder. Latches an 8-byte command, decodes it
// per phase and cartridge type, updates phase/key/status/error state and
// streams the response words. Assumes cfg inputs change only while idle.
module cart_cmd_responder
    import cart_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROM_MIB_W-1:0] cfg_rom_mib,
    input  logic                 cfg_nand,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [63:0]          cmd_data,
    input  logic [LEN_W-1:0]     cmd_len_words,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [31:0]          rsp_data,
    output logic                 rsp_done,
    output logic                 rom_rd_en,
    output logic [31:0]          rom_rd_addr,
    input  logic [31:0]          rom_rd_data,
    output logic                 key_enable,
    output logic                 err_flag
);
    logic        accept, main_q, key_q, err_q;
    logic [7:0]  status_q;
    logic [31:0] chip_id, fill_word;
    dec_t        dec;
    logic        unused_tail;

    assign accept      = cmd_valid && cmd_ready;
    assign unused_tail = ^cmd_data[23:0];

    cart_id_gen i_id (
        .rom_mib   (cfg_rom_mib),
        .nand_type (cfg_nand),
        .chip_id   (chip_id)
    );

    cart_cmd_decode i_dec (
        .opcode     (cmd_data[63:56]),
        .main_phase (main_q),
        .nand_type  (cfg_nand),
        .dec        (dec)
    );

    // Phase, key enable, sticky error and NAND status updates on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q   <= 1'b0;
            key_q    <= 1'b0;
            err_q    <= 1'b0;
            status_q <= '0;
        end else if (accept) begin
            if (dec.to_main) main_q <= 1'b1;
            if (dec.key_on)  key_q  <= 1'b1;
            if (dec.bad)     err_q  <= 1'b1;
            if (dec.st_clear)     status_q <= '0;
            else if (dec.st_save) status_q <= status_q | STAT_SAVE_BIT;
        end
    end

    // Fixed response word for non-ROM commands.
    always_comb begin
        case (dec.fill)
            FILL_ID:     fill_word = chip_id;
            FILL_STATUS: fill_word = {4{status_q}};
            default:     fill_word = '0;
        endcase
    end

    cart_word_seq #(.ADDR_W(32), .LEN_W(LEN_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_len   (cmd_len_words),
        .start_addr  (cmd_data[55:24]),
        .start_rom   (dec.fill == FILL_ROM),
        .start_word  (fill_word),
        .cmd_ready   (cmd_ready),
        .rom_rd_en   (rom_rd_en),
        .rom_rd_addr (rom_rd_addr),
        .rom_rd_data (rom_rd_data),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_ready   (rsp_ready),
        .rsp_done    (rsp_done)
    );

    assign key_enable = key_q;
    assign err_flag   = err_q;
endmodule

// File: rtl/cart_cmd_chk.sv
// Protocol checker for cart_cmd_responder, attached by bind.
module cart_cmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_data,
    input logic        rsp_done,
    input logic        rom_rd_en,
    input logic [31:0] rom_rd_addr,
    input logic        err_flag,
    input logic [7:0]  status
);
    // R11: a word waiting for ready stays put.
    a_r11_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
    // R11: done never overlaps a pending word.
    a_r11_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !rsp_valid);
    // R11: no command taken while words are pending.
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);
    // R6: reads are word aligned.
    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_en |-> rom_rd_addr[1:0] == 2'b00);
    // R6: one cycle of latency before a word is offered.
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_en |=> !rsp_valid && !rom_rd_en);
    // R10: error flag is sticky.
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    // R8: status bit 7 never sets.
    a_r8_bit7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7]);
endmodule

bind cart_cmd_responder cart_cmd_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_done    (rsp_done),
    .rom_rd_en   (rom_rd_en),
    .rom_rd_addr (rom_rd_addr),
    .err_flag    (err_flag),
    .status      (status_q)
);

// File: tb/test_cart_cmd_responder.sv
`timescale 1ns/1ps
module test_cart_cmd_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_rom_mib = 16'd64;
    logic        cfg_nand = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_data = '0;
    logic [9:0]  cmd_len_words = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;
    logic        rsp_done;
    logic        rom_rd_en;
    logic [31:0] rom_rd_addr;
    logic [31:0] rom_rd_data = '0;
    logic        key_enable;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    logic [31:0] got [0:15];
    int          got_n;

    always #10 clk = ~clk;

    cart_cmd_responder i_cart_cmd_responder (.*);

    function automatic logic [31:0] rom_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A00, a[15:0]};
    endfunction

    // ROM model with one cycle of latency.
    always_ff @(posedge clk) if (rom_rd_en) rom_rd_data <= rom_word(rom_rd_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic send_cmd(input logic [7:0] op, input logic [31:0] addr, input int len);
        @(negedge clk);
        cmd_valid     = 1'b1;
        cmd_data      = {op, addr, 24'h0};
        cmd_len_words = 10'(len);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic collect(input bit backpressure);
        int  guard = 0;
        bit  seen_done = 0;
        got_n = 0;
        while (!seen_done && guard < 300) begin
            @(negedge clk);
            guard++;
            if (rsp_done) seen_done = 1;
            else begin
                rsp_ready = backpressure ? (guard % 3 == 0) : 1'b1;
                if (rsp_valid && rsp_ready) begin
                    if (got_n < 16) got[got_n] = rsp_data;
                    got_n++;
                end
            end
        end
        rsp_ready = 1'b0;
        chk("R11 done pulse seen", 32'(seen_done), 32'd1);
    endtask

    task automatic run(input logic [7:0] op, input logic [31:0] addr, input int len, input bit bp);
        send_cmd(op, addr, len);
        collect(bp);
        chk("R11 word count", 32'(got_n), 32'(len));
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 rsp_done", 32'(rsp_done), 0);
        chk("R1 cmd_ready", 32'(cmd_ready), 1);
        chk("R1 err_flag", 32'(err_flag), 0);
        chk("R1 key_enable", 32'(key_enable), 0);
    endtask

    task automatic t_id(input logic [15:0] mib, input logic nand_t, input logic [31:0] exp, input string req);
        do_reset();
        cfg_rom_mib = mib;
        cfg_nand    = nand_t;
        run(8'h10 | 8'(mib[3:0]), 32'h0, 3, 1'b0);
        for (int i = 0; i < 3; i++) chk(req, got[i], exp);
    endtask

    task automatic t_secure_ops();
        do_reset();
        cfg_rom_mib = 16'd64; cfg_nand = 1'b0;
        run(8'h4C, 32'h0, 2, 1'b0);
        chk("R5 key_enable set by 0x4x", 32'(key_enable), 1);
        chk("R5 0x4x zero word", got[0], 0);
        run(8'hA3, 32'h0, 1, 1'b0);
        chk("R5 0xAx zero word", got[0], 0);
        run(8'h10, 32'h0, 1, 1'b0);
        chk("R5 0x1x not ID in main phase", got[0], 0);
        chk("R10 error after main-phase 0x1x", 32'(err_flag), 1);
    endtask

    task automatic t_rom_page();
        do_reset();
        cfg_rom_mib = 16'd64; cfg_nand = 1'b0;
        run(8'hA0, 32'h0, 1, 1'b0);
        run(8'hB7, 32'h00000FF9, 4, 1'b1);
        for (int i = 0; i < 4; i++)
            chk("R6 R7 page crossing read word", got[i], rom_word(32'h00000FF8 + 32'(4 * i)));
        run(8'hB7, 32'h12345000, 2, 1'b0);
        chk("R6 big-endian address word0", got[0], rom_word(32'h12345000));
        chk("R6 big-endian address word1", got[1], rom_word(32'h12345004));
        chk("R6 no error on valid read", 32'(err_flag), 0);
    endtask

    task automatic t_nand_status();
        do_reset();
        cfg_rom_mib = 16'd256; cfg_nand = 1'b1;
        run(8'hA0, 32'h0, 1, 1'b0);
        run(8'hD6, 32'h0, 2, 1'b0);
        chk("R9 status initially zero", got[1], 32'h0);
        run(8'hB2, 32'h0, 1, 1'b0);
        chk("R9 0xB2 zero word", got[0], 32'h0);
        run(8'hD6, 32'h0, 3, 1'b1);
        for (int i = 0; i < 3; i++) chk("R9 status bit5 replicated", got[i], 32'h20202020);
        run(8'h94, 32'h0, 2, 1'b0);
        chk("R8 0x94 zero word", got[1], 32'h0);
        run(8'hD6, 32'h0, 1, 1'b0);
        chk("R8 status cleared", got[0], 32'h0);
        chk("R8 no error", 32'(err_flag), 0);
        run(8'h55, 32'h0, 2, 1'b0);
        chk("R10 unknown NAND opcode zero", got[1], 32'h0);
        chk("R10 unknown NAND opcode error", 32'(err_flag), 1);
        run(8'hD6, 32'h0, 1, 1'b0);
        chk("R10 error stays set", 32'(err_flag), 1);
    endtask

    task automatic t_plain_rejects();
        do_reset();
        cfg_rom_mib = 16'd64; cfg_nand = 1'b0;
        run(8'hA0, 32'h0, 1, 1'b0);
        run(8'hB2, 32'h0, 1, 1'b0);
        chk("R10 plain rejects 0xB2 error", 32'(err_flag), 1);
        run(8'hD6, 32'h0, 2, 1'b0);
        chk("R10 plain 0xD6 returns zero", got[0], 32'h0);
        do_reset();
        run(8'h30, 32'h0, 1, 1'b0);
        chk("R10 unknown secure opcode zero", got[0], 32'h0);
        chk("R10 unknown secure opcode error", 32'(err_flag), 1);
    endtask

    task automatic t_zero_len();
        do_reset();
        run(8'h10, 32'h0, 0, 1'b0);
        @(negedge clk);
        chk("R11 idle after zero length", 32'(cmd_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_id(16'd64,  1'b0, 32'h00003FC2, "R2 ID 64 MiB");
        t_id(16'd128, 1'b0, 32'h00007FC2, "R2 ID 128 MiB boundary");
        t_id(16'd1,   1'b0, 32'h000000C2, "R2 ID 1 MiB");
        t_id(16'd512, 1'b0, 32'h0000FEC2, "R3 ID 512 MiB");
        t_id(16'd256, 1'b1, 32'h0800FFC2, "R4 ID NAND 256 MiB");
        t_id(16'd32,  1'b1, 32'h08001FC2, "R4 ID NAND 32 MiB");
        t_secure_ops();
        t_rom_page();
        t_nand_status();
        t_plain_rejects();
        t_zero_len();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule